// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block produces the processor reset line for a board-level supervisor. It takes a digitised supply-good flag from an external comparator (high when the supply sits above the trip threshold, low in a brownout or when the supply is under the 1 V floor), a single-cycle expiry strobe from a separate watchdog block, and a polarity select. Reset is active from the moment power is applied, through the synchronous power-on reset input. It is released only once the supply has been good, with no watchdog expiry, for an unbroken hold interval.

Any loss of supply-good, or any watchdog strobe, puts reset back on in the next cycle and restarts the hold count from zero. The hold interval is a parameter in clock cycles. The default is 200 ms at 100 MHz, and a bench can use a short value. The pad is modelled as an open-drain pull enable. For an active-low reset the pad is pulled while reset is on. For an active-high reset it is pulled while reset is off, and an external pull-up gives the high level.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst` is high, `rst_active` is 1 in the next cycle and the hold count is zero. `pad_pull_en` resets to 1 when `pol_high`=0 and to 0 when `pol_high`=1.
- R2: With `supply_ok`=1 and `wdt_expire`=0 on HOLD_CYCLES consecutive rising edges, `rst_active` goes to 0 at exactly the HOLD_CYCLES-th of those edges, and not before.
- R3: `supply_ok`=0 sampled at an edge makes `rst_active` 1 after that edge.
- R4: After a brownout, `rst_active` stays 1 until a fresh run of HOLD_CYCLES good cycles has completed.
- R5: `wdt_expire`=1 sampled at an edge makes `rst_active` 1 after that edge, whether reset was off or still in its hold phase.
- R6: `pad_pull_en` is registered from the previous cycle's `rst_active`. It equals that value when `pol_high`=0 (active-low pad, pulled while in reset) and its inverse when `pol_high`=1.
- R7: A single cycle of `supply_ok`=0 during the hold phase restarts the count from zero, so HOLD_CYCLES further good cycles are needed.
- R8: A watchdog-caused reset follows the same hold path. If the supply is bad after the strobe, release waits until the supply has been good for the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_ok | input | 1 | Comparator flag, 1 when supply is above trip |
| wdt_expire | input | 1 | Watchdog expiry strobe |
| pol_high | input | 1 | 0 selects active-low pad, 1 selects active-high pad |
| rst_active | output | 1 | Logical reset state, 1 while reset is asserted |
| pad_pull_en | output | 1 | Open-drain pull-down enable for the reset pad |

## Verification
The bench aims at the edges of the hold window. It checks release at exactly the HOLD_CYCLES-th good cycle: a counter that is off by one releases a cycle early or late. It checks a supply glitch one cycle before release: a design that pauses the count instead of clearing it releases too soon. It checks a watchdog strobe during the hold and while the supply is bad: a design that lets the watchdog run a separate timer would release while the supply is still bad. It switches the polarity at run time: a swapped pad encoding shows up at once as a pad pulled while reset is off.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } pol_e;

  // pull enable for an open-drain pad given logical reset state
  function automatic logic pull_for(input pol_e pol, input logic active);
    return (pol == POL_HIGH) ? ~active : active;
  endfunction
endpackage

// File: rtl/supv_hold_ctr.sv
module supv_hold_ctr #(
  parameter int HOLD_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic wdt_expire,
  output logic active
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] count;
  logic             trip;

  assign trip = ~supply_ok | wdt_expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      count  <= '0;
    end else if (trip) begin
      active <= 1'b1;
      count  <= '0;
    end else if (active) begin
      if (count == LAST) begin
        active <= 1'b0;
        count  <= '0;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  // checker: independent run-length of qualifying cycles
  logic [CNT_W:0] good_run;
  always_ff @(posedge clk) begin
    if (rst || trip) good_run <= '0;
    else if (good_run < (CNT_W+1)'(HOLD_CYCLES)) good_run <= good_run + 1'b1;
  end

  assert_por_R1: assert property (@(posedge clk) rst |=> active);
  assert_drop_R3: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> active);
  assert_wdt_R5: assert property (@(posedge clk) disable iff (rst)
    wdt_expire |=> active);
  assert_full_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (good_run >= (CNT_W+1)'(HOLD_CYCLES)));
endmodule

// File: rtl/supv_pad_stage.sv
module supv_pad_stage
  import supv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic pol_high,
  output logic pad_pull_en
);
  pol_e pol;
  assign pol = pol_e'(pol_high);

  always_ff @(posedge clk) begin
    if (rst) pad_pull_en <= pull_for(pol, 1'b1);
    else     pad_pull_en <= pull_for(pol, active);
  end

  assert_pad_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (pad_pull_en == ($past(pol_high) ? !$past(active) : $past(active))));
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int HOLD_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic wdt_expire,
  input  logic pol_high,
  output logic rst_active,
  output logic pad_pull_en
);
  supv_hold_ctr #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .wdt_expire (wdt_expire),
    .active     (rst_active)
  );

  supv_pad_stage u_pad (
    .clk         (clk),
    .rst         (rst),
    .active      (rst_active),
    .pol_high    (pol_high),
    .pad_pull_en (pad_pull_en)
  );
endmodule

// File: tb/tb_supv_reset_gen.sv
module tb_supv_reset_gen;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic wdt_expire = 1'b0;
  logic pol_high = 1'b0;
  logic rst_active, pad_pull_en;

  int checks = 0;
  int errors = 0;
  int run = 0;
  bit m_act = 1'b1;
  bit m_pad = 1'b1;

  always #5 clk = ~clk;

  supv_reset_gen #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .wdt_expire(wdt_expire),
    .pol_high(pol_high), .rst_active(rst_active), .pad_pull_en(pad_pull_en)
  );

  task automatic cyc(input bit r, input bit ok, input bit wd, input bit pol, input string tag);
    rst = r; supply_ok = ok; wdt_expire = wd; pol_high = pol;
    if (r) begin
      m_act = 1'b1; run = 0; m_pad = pol ? 1'b0 : 1'b1;
    end else begin
      m_pad = pol ? !m_act : m_act;
      if (!ok || wd) begin m_act = 1'b1; run = 0; end
      else if (m_act) begin
        run++;
        if (run == HOLD) begin m_act = 1'b0; run = 0; end
      end
    end
    @(posedge clk); #2;
    checks++;
    if (rst_active !== m_act) begin
      errors++;
      $display("FAIL %s rst_active actual %b expected %b", tag, rst_active, m_act);
    end
    checks++;
    if (pad_pull_en !== m_pad) begin
      errors++;
      $display("FAIL %s pad_pull_en actual %b expected %b", tag, pad_pull_en, m_pad);
    end
  endtask

  task automatic good(input int n, input bit pol, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, pol, tag);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1, 1, 0, 0, "R1"); cyc(1, 1, 0, 0, "R1");
    good(HOLD + 3, 0, "R2");               // exact release point
    cyc(0, 0, 0, 0, "R3");                 // brownout
    cyc(0, 0, 0, 0, "R3");
    good(HOLD - 1, 0, "R4");
    cyc(0, 0, 0, 0, "R7");                 // glitch just before release
    good(HOLD + 2, 0, "R7");
    cyc(0, 1, 1, 0, "R5");                 // watchdog while running
    good(4, 0, "R5");
    cyc(0, 1, 1, 0, "R5");                 // watchdog in hold phase
    good(HOLD + 2, 0, "R5");
    cyc(0, 1, 1, 1, "R8");                 // watchdog then bad supply
    cyc(0, 0, 0, 1, "R8");
    cyc(0, 0, 0, 1, "R8");
    good(HOLD + 2, 1, "R8");
    cyc(0, 1, 0, 0, "R6"); cyc(0, 1, 0, 1, "R6");
    cyc(0, 0, 0, 1, "R6"); cyc(0, 0, 0, 0, "R6");
    cyc(1, 1, 0, 1, "R1");                 // reset with active-high pad
    good(HOLD + 2, 1, "R4");
    for (int k = 0; k < 20; k++)
      cyc(0, (k % 7) != 3, (k % 11) == 5, k[2], "R7");
    good(HOLD + 1, 0, "R2");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule